// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Generator

This block sits on the bus-master side of a processor. It watches seven active-low interrupt request lines and passes them through a clock-domain synchronizer. It then picks the highest pending level and compares it with a programmable mask. The top level is not compared with the mask: it fires on a falling edge of its line.

When a request wins and the instruction-boundary input is high, the block runs one acknowledge read cycle on a 32-bit address and data bus. During that cycle it presents a fixed encoding: the function code, a special address pattern, a one-byte size, read direction, the address and data strobes, and the acknowledge strobe for the winning level.

The responding device ends the cycle in one of two ways. It can return a vector byte with data-size acknowledge, where the byte lane depends on its port width. Or, when it has no vector, it asserts autovector. The block then releases its strobes and reports the vector, the level and whether the vector was generated internally.

Top module: `irq_ack_seq`

## Requirements
- R1: Request lines pass through a two-stage synchronizer. A request driven just after a clock edge cannot put the address strobe low before the fourth following rising edge.
- R2: Levels 1 to 6 start a cycle only when the highest active one among them is strictly greater than `ipl_mask` (3 bits). When several are active, the highest level is acknowledged first. A mask of 7 blocks all six of them.
- R3: Level 7 is taken on each high-to-low transition of its line, whatever the mask. Holding the line low after it has been acknowledged starts no further cycle.
- R4: A cycle starts only while `insn_done` is high. A request that is pending while `insn_done` is low waits.
- R5: While the address strobe is low: `fc` = 4'b0111, `rw` = 1 (read) and `siz` = 2'b01 (one byte).
- R6: While the address strobe is low, `addr` = {28'hFFFFFFF, level, 1'b1}. This puts the level on bits 3..1, hex F on bits 19..16, and ones on every other bit.
- R7: The cycle opens with one address-phase clock in which the strobes are high. After that, `as_n`, `ds_n` and `iack_n[level-1]` go low together. No other `iack_n` bit is low at any time, and all bits of `iack_n` are high whenever `as_n` is high.
- R8: The vector byte is taken from `dsack_n` = 2'b01 (8-bit port), which selects `data_in[31:24]`; from 2'b10 (16-bit port), which selects `data_in[23:16]`; or from 2'b00 (32-bit port), which selects `data_in[7:0]`.
- R9: If `avec_n` is low and `dsack_n` = 2'b11, the reported vector is 24 + level and `vec_auto` = 1. If both are asserted, data-size acknowledge takes precedence and `vec_auto` = 0.
- R10: After the termination is sampled, the strobes are high on the next clock. `vec_valid` pulses for exactly one clock with `vec_num`, `vec_lvl` and `vec_auto`. No new cycle begins until `dsack_n` = 2'b11 and `avec_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low requests; bit i is level i+1 |
| ipl_mask | input | 3 | Interrupt mask level |
| insn_done | input | 1 | High at an instruction boundary |
| data_in | input | 32 | Data bus |
| dsack_n | input | 2 | Active-low data-size acknowledge |
| avec_n | input | 1 | Active-low autovector termination |
| addr | output | 32 | Address bus (zero when idle) |
| fc | output | 4 | Function code (zero when idle) |
| siz | output | 2 | Transfer size |
| rw | output | 1 | 1 = read |
| as_n | output | 1 | Address strobe |
| ds_n | output | 1 | Data strobe |
| iack_n | output | 7 | Per-level acknowledge strobes |
| vec_valid | output | 1 | One-clock result strobe |
| vec_num | output | 8 | Acknowledged vector number |
| vec_auto | output | 1 | Vector came from autovector |
| vec_lvl | output | 3 | Acknowledged level |

## Verification
A single mid-level request on a 32-bit port establishes the base encoding and the synchronizer delay. Two simultaneous requests then separate priority from arrival order. A level equal to the mask, and a pending request with the boundary input low, show that compare and gating hold a cycle off rather than merely delay it. All three port widths, a pure autovector, and a combined acknowledge-plus-autovector distinguish lane selection from the autovector path. A held level-7 line under a full mask separates edge-triggered from level-triggered behaviour for the top level.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int NLVL   = 7;
  localparam int LVL_W  = 3;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;

  localparam logic [3:0] FC_CPU_SPACE = 4'b0111;
  localparam logic [1:0] SIZ_BYTE     = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STRB, ST_REL} ack_st_t;

  // acknowledge address: all ones except the level on bits 3..1
  function automatic logic [ADDR_W-1:0] ack_addr(input logic [LVL_W-1:0] lvl);
    return {{(ADDR_W-4){1'b1}}, lvl, 1'b1};
  endfunction

  // byte lane chosen by the port width encoded on the acknowledge pair
  function automatic logic [VEC_W-1:0] pick_lane(input logic [1:0] dsk_n,
                                                 input logic [DATA_W-1:0] d);
    case (dsk_n)
      2'b01:   return d[31:24];
      2'b10:   return d[23:16];
      default: return d[7:0];
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] auto_vec(input logic [LVL_W-1:0] lvl,
                                                input int base);
    return VEC_W'(base) + {{(VEC_W-LVL_W){1'b0}}, lvl};
  endfunction

  // highest set bit of a maskable request vector, as a level number (0 = none)
  function automatic logic [LVL_W-1:0] top_level(input logic [NLVL-2:0] act);
    logic [LVL_W-1:0] lv;
    lv = '0;
    for (int i = 0; i < NLVL-1; i++)
      if (act[i]) lv = LVL_W'(i + 1);
    return lv;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync
  import irq_ack_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_n,
  output logic [NLVL-1:0] req_s
);
  logic [NLVL-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= '0;
        else if (s == 0) chain[s] <= ~irq_n;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign req_s = chain[STAGES-1];
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_ack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  req_s,
  input  logic [LVL_W-1:0] mask,
  input  logic             clr_nmi,
  output logic             pend,
  output logic [LVL_W-1:0] pend_lvl,
  output logic             nmi_edge
);
  logic             top_d;
  logic             nmi_pend;
  logic [LVL_W-1:0] mask_top;

  assign nmi_edge = req_s[NLVL-1] & ~top_d;
  assign mask_top = top_level(req_s[NLVL-2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_d    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      top_d    <= req_s[NLVL-1];
      nmi_pend <= nmi_edge | (nmi_pend & ~clr_nmi);
    end
  end

  always_comb begin
    if (nmi_pend) begin
      pend     = 1'b1;
      pend_lvl = LVL_W'(NLVL);
    end else begin
      pend     = (mask_top > mask);
      pend_lvl = mask_top;
    end
  end

  // R3
  nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |=> nmi_pend);
  // R2
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pend_lvl != LVL_W'(NLVL)) |-> (pend_lvl > mask));
endmodule

// File: rtl/ack_fsm.sv
module ack_fsm
  import irq_ack_pkg::*;
#(
  parameter int AUTO_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic [LVL_W-1:0]  pend_lvl,
  input  logic              insn_done,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        dsack_n,
  input  logic              avec_n,
  output logic              clr_nmi,
  output logic [ADDR_W-1:0] addr,
  output logic [3:0]        fc,
  output logic [1:0]        siz,
  output logic              rw,
  output logic              as_n,
  output logic              ds_n,
  output logic [NLVL-1:0]   iack_n,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic              vec_auto,
  output logic [LVL_W-1:0]  vec_lvl
);
  ack_st_t          st, st_nx;
  logic [LVL_W-1:0] lvl_q;
  logic             start, term, by_dsack, released, in_cycle, addr_phase;

  assign by_dsack   = (dsack_n != 2'b11);
  assign term       = by_dsack | ~avec_n;
  assign released   = (dsack_n == 2'b11) & avec_n;
  assign start      = (st == ST_IDLE) & pend & insn_done & released;
  assign clr_nmi    = start & (pend_lvl == LVL_W'(NLVL));
  assign in_cycle   = (st == ST_ADDR) | (st == ST_STRB);
  assign addr_phase = (st == ST_ADDR);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start) st_nx = ST_ADDR;
      ST_ADDR: st_nx = ST_STRB;
      ST_STRB: if (term) st_nx = ST_REL;
      ST_REL:  if (released) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lvl_q     <= '0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
      vec_auto  <= 1'b0;
      vec_lvl   <= '0;
    end else begin
      st        <= st_nx;
      vec_valid <= 1'b0;
      if (start) lvl_q <= pend_lvl;
      if (st == ST_STRB && term) begin
        vec_valid <= 1'b1;
        vec_lvl   <= lvl_q;
        vec_auto  <= ~by_dsack;
        vec_num   <= by_dsack ? pick_lane(dsack_n, data_in)
                              : auto_vec(lvl_q, AUTO_BASE);
      end
    end
  end

  always_comb begin
    addr   = in_cycle ? ack_addr(lvl_q) : '0;
    fc     = in_cycle ? FC_CPU_SPACE : 4'b0000;
    siz    = in_cycle ? SIZ_BYTE : 2'b00;
    rw     = 1'b1;
    as_n   = ~(st == ST_STRB);
    ds_n   = ~(st == ST_STRB);
    iack_n = '1;
    if (st == ST_STRB) iack_n[lvl_q - 1'b1] = 1'b0;
  end

  // R7
  iack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~iack_n));
  // R7
  iack_with_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (&iack_n));
  // R5
  fc_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (fc == 4'b0111 && rw && siz == 2'b01));
  // R4
  start_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_phase) |-> $past(insn_done));
  // R10
  vec_after_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(!ds_n) && $past(term)));
  // R10
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && term) |=> (as_n && ds_n));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AUTO_BASE   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  irq_n,
  input  logic [2:0]  ipl_mask,
  input  logic        insn_done,
  input  logic [31:0] data_in,
  input  logic [1:0]  dsack_n,
  input  logic        avec_n,
  output logic [31:0] addr,
  output logic [3:0]  fc,
  output logic [1:0]  siz,
  output logic        rw,
  output logic        as_n,
  output logic        ds_n,
  output logic [6:0]  iack_n,
  output logic        vec_valid,
  output logic [7:0]  vec_num,
  output logic        vec_auto,
  output logic [2:0]  vec_lvl
);
  logic [NLVL-1:0]  req_s;
  logic             pend, clr_nmi, nmi_edge;
  logic [LVL_W-1:0] pend_lvl;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .req_s(req_s));

  irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .mask(ipl_mask),
    .clr_nmi(clr_nmi), .pend(pend), .pend_lvl(pend_lvl), .nmi_edge(nmi_edge));

  ack_fsm #(.AUTO_BASE(AUTO_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pend(pend), .pend_lvl(pend_lvl),
    .insn_done(insn_done), .data_in(data_in), .dsack_n(dsack_n),
    .avec_n(avec_n), .clr_nmi(clr_nmi), .addr(addr), .fc(fc), .siz(siz),
    .rw(rw), .as_n(as_n), .ds_n(ds_n), .iack_n(iack_n),
    .vec_valid(vec_valid), .vec_num(vec_num), .vec_auto(vec_auto),
    .vec_lvl(vec_lvl));
endmodule

// File: tb/sim_irq_ack_seq.sv
module sim_irq_ack_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_n = '1;
  logic [2:0]  ipl_mask = '0;
  logic        insn_done = 1'b1;
  logic [31:0] data_in = '0;
  logic [1:0]  dsack_n = 2'b11;
  logic        avec_n = 1'b1;
  logic [31:0] addr;
  logic [3:0]  fc;
  logic [1:0]  siz;
  logic        rw, as_n, ds_n, vec_valid, vec_auto;
  logic [6:0]  iack_n;
  logic [7:0]  vec_num;
  logic [2:0]  vec_lvl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [11:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ack_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(expq.size() == 0, "R10 pending results", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compare each reported vector against the scoreboard
  always @(negedge clk) begin
    cycles++;
    if (rst_n && vec_valid) begin
      if (expq.size() == 0) chk(1'b0, "R10 unexpected result", {20'd0, vec_auto, vec_lvl, vec_num}, 0);
      else begin
        logic [11:0] e;
        e = expq.pop_front();
        chk({vec_auto, vec_lvl, vec_num} == e, "R8 R9 R10 vector result",
            {20'd0, vec_auto, vec_lvl, vec_num}, {20'd0, e});
      end
    end
    if (cycles > 50000) begin
      chk(1'b0, "watchdog", cycles, 50000);
      finish_run();
    end
  end

  // responder: wait for the strobes, check the encoding, terminate the cycle
  task automatic do_ack(input logic [2:0] lvl, input logic [1:0] dsk,
                        input logic av, input logic [31:0] d,
                        input logic [7:0] exp_vec, input logic exp_auto,
                        input bit release_req);
    int n = 0;
    while (as_n && n < 200) begin @(negedge clk); n++; end
    chk(!as_n, "R2 cycle started", {31'd0, as_n}, 0);
    chk(!ds_n, "R7 data strobe with address strobe", {31'd0, ds_n}, 0);
    chk(iack_n == ~(7'd1 << (lvl - 1)), "R7 matching acknowledge strobe", {25'd0, iack_n}, {25'd0, ~(7'd1 << (lvl - 1))});
    chk(fc == 4'b0111 && rw && siz == 2'b01, "R5 fc rw siz", {25'd0, fc, rw, siz}, {25'd0, 4'b0111, 1'b1, 2'b01});
    chk(addr == {28'hFFFFFFF, lvl, 1'b1}, "R6 address pattern", addr, {28'hFFFFFFF, lvl, 1'b1});
    expq.push_back({exp_auto, lvl, exp_vec});
    if (release_req) irq_n[lvl-1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!as_n, "R10 strobes held until termination", {31'd0, as_n}, 0);
    data_in = d; dsack_n = dsk; avec_n = av;
    @(negedge clk);
    chk(as_n && ds_n && (&iack_n), "R10 strobes negated", {29'd0, as_n, ds_n, &iack_n}, 32'h7);
    @(negedge clk);
    chk(as_n, "R10 no restart before release", {31'd0, as_n}, 1);
    dsack_n = 2'b11; avec_n = 1'b1; data_in = '0;
    @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!as_n) seen = 1; end
    chk(!seen, req, {31'd0, seen}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(as_n && ds_n && iack_n == 7'h7F && !vec_valid, "R7 reset state",
        {23'd0, as_n, ds_n, iack_n, vec_valid}, {23'd0, 1'b1, 1'b1, 7'h7F, 1'b0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: level 3, 32-bit port
    irq_n[2] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(as_n, "R1 synchronizer delay", {31'd0, as_n}, 1);
    do_ack(3'd3, 2'b00, 1'b1, 32'h1234_5640, 8'h40, 1'b0, 1);

    // R2: levels 5 and 2 together, mask 1; 8-bit then 32-bit port
    ipl_mask = 3'd1;
    irq_n[4] = 1'b0; irq_n[1] = 1'b0;
    do_ack(3'd5, 2'b01, 1'b1, 32'h8100_0000, 8'h81, 1'b0, 1);
    do_ack(3'd2, 2'b00, 1'b1, 32'h0000_0099, 8'h99, 1'b0, 1);

    // R2: level equal to mask waits; R8 16-bit port after lowering mask
    ipl_mask = 3'd4;
    irq_n[3] = 1'b0;
    quiet(20, "R2 level equal to mask held off");
    ipl_mask = 3'd3;
    do_ack(3'd4, 2'b10, 1'b1, 32'h00A5_0000, 8'hA5, 1'b0, 1);

    // R4: boundary input low holds the request; R9 autovector
    ipl_mask = 3'd0;
    insn_done = 1'b0;
    irq_n[5] = 1'b0;
    quiet(20, "R4 no cycle without boundary");
    insn_done = 1'b1;
    do_ack(3'd6, 2'b11, 1'b0, 32'hFFFF_FFFF, 8'd30, 1'b1, 1);

    // R9: both terminations, acknowledge wins
    irq_n[0] = 1'b0;
    do_ack(3'd1, 2'b00, 1'b0, 32'h0000_0042, 8'h42, 1'b0, 1);

    // R3: level 7 under full mask, held low; level 6 masked meanwhile
    ipl_mask = 3'd7;
    irq_n[5] = 1'b0;
    irq_n[6] = 1'b0;
    do_ack(3'd7, 2'b11, 1'b0, 32'h0, 8'd31, 1'b1, 0);
    quiet(30, "R3 held level 7 does not retrigger");
    irq_n = '1;
    repeat (4) @(negedge clk);
    irq_n[6] = 1'b0;
    do_ack(3'd7, 2'b00, 1'b1, 32'h0000_00C7, 8'hC7, 1'b0, 0);
    irq_n = '1;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule